// File: doc/BRIEF.md
# Two-Lane Sample Transport Framer and Deframer

This block sits between two data converters and the serial lane logic of a two-lane converter link. In the transmit direction it takes 14-bit samples from two converters, widens each one to a 16-bit word and packs the words into one 32-bit parallel word per lane per link clock. Each lane word holds two consecutive frames, and each frame holds exactly one sample. The receive direction undoes the same packing and returns the two 14-bit samples of each converter.

Each converter owns one lane, so no sample is ever split across lanes. Samples carry no control bits, and no control words are inserted. Both directions are a single register stage deep, and each carries its valid strobe through with the same one-cycle delay. The two directions share only the clock and the reset, so they can run at the same time on unrelated data.

Top module: `jtm_transport`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no valid input, `tx_vld_o` and `rx_vld_o` are 0 and `tx_lane_o` and `rx_smp_o` are all zero.
- R2: `tx_vld_o` equals `tx_vld_i` delayed by exactly one clock. When `tx_vld_i` is high, the packed lane words appear on `tx_lane_o` on the next clock.
- R3: The samples of converter c are carried only on lane c, which is `tx_lane_o[c*32 +: 32]` and `rx_lane_i[c*32 +: 32]`. The sample for converter c, frame f sits at `tx_smp_i[(c*2+f)*14 +: 14]`, and the same position is used in `rx_smp_o`.
- R4: Each transmitted 16-bit frame word is `{sample[13:0], 2'b00}`. The sample fills the upper 14 bits and the two low tail bits are zero.
- R5: Within a lane word, frame 0 (the earlier frame) occupies bits [31:16] and frame 1 occupies bits [15:0]. The most significant octet of each frame word comes first on the lane, so the first octet of the lane word is bits [31:24].
- R6: `rx_vld_o` equals `rx_vld_i` delayed by exactly one clock. When `rx_vld_i` is high, `rx_smp_o` returns the samples on the next clock, taking frame 0 from bits [31:18] of each lane word and frame 1 from bits [15:2].
- R7: On receive, the two tail bits of each frame word (lane bits [17:16] and [1:0]) do not affect `rx_smp_o`.
- R8: In a clock where the valid input of a direction is low, that direction's data output keeps its previous value.
- R9: The transmit and receive directions work independently. Valid traffic in both directions in the same clock gives each direction the same result it would give alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_vld_i | input | 1 | Transmit samples valid |
| tx_smp_i | input | 56 | Transmit samples, converter-major, frame 0 first |
| tx_vld_o | output | 1 | Transmit lane words valid |
| tx_lane_o | output | 64 | Transmit lane words, lane 0 in the low 32 bits |
| rx_vld_i | input | 1 | Receive lane words valid |
| rx_lane_i | input | 64 | Receive lane words, lane 0 in the low 32 bits |
| rx_vld_o | output | 1 | Receive samples valid |
| rx_smp_o | output | 56 | Receive samples, same layout as `tx_smp_i` |

## Verification
Packing on transmit and unpacking on receive can happen in the same clock, because the two paths share only the clock and the reset. The bench provokes this by driving valid sample sets into the transmit side while, in the same cycles, it drives different lane words, with nonzero tail bits, into the receive side. Each output is then compared with the value computed from the packing rules for its own input alone. This shows that neither path picks up data or strobe timing from the other.

// File: rtl/jtm_pkg.sv
package jtm_pkg;
   localparam int OCTET_W      = 8;
   localparam int DEF_SMP_W    = 14;
   localparam int DEF_WORD_W   = 16;
   localparam int DEF_LANES    = 2;
   localparam int DEF_FPW      = 2;
endpackage

// File: rtl/jtm_tx_lane.sv
module jtm_tx_lane
   import jtm_pkg::*;
#(
   parameter int SMP_W  = DEF_SMP_W,
   parameter int WORD_W = DEF_WORD_W,
   parameter int FPW    = DEF_FPW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [FPW*SMP_W-1:0]    smp_i,
   output logic [FPW*WORD_W-1:0]   lane_o
);
   localparam int TAIL_W  = WORD_W - SMP_W;
   localparam int OCT_N   = WORD_W / OCTET_W;
   localparam int LANE_W  = FPW * WORD_W;

   logic [LANE_W-1:0] lane_d;

   for (genvar f = 0; f < FPW; f++) begin : g_frame
      logic [WORD_W-1:0] word;
      // widen: sample in the top bits
      if (TAIL_W == 0) begin : g_notail
         assign word = smp_i[f*SMP_W +: SMP_W];
      end else begin : g_tail
         assign word = {smp_i[f*SMP_W +: SMP_W], {TAIL_W{1'b0}}};
      end
      // octet o is sent o-th; earlier frame sits higher in the lane word
      for (genvar o = 0; o < OCT_N; o++) begin : g_oct
         assign lane_d[(FPW-f)*WORD_W-1-o*OCTET_W -: OCTET_W] =
            word[WORD_W-1-o*OCTET_W -: OCTET_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_o <= '0;
      else if (vld_i) lane_o <= lane_d;
   end
endmodule

// File: rtl/jtm_rx_lane.sv
module jtm_rx_lane
   import jtm_pkg::*;
#(
   parameter int SMP_W  = DEF_SMP_W,
   parameter int WORD_W = DEF_WORD_W,
   parameter int FPW    = DEF_FPW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [FPW*WORD_W-1:0]   lane_i,
   output logic [FPW*SMP_W-1:0]    smp_o
);
   localparam int TAIL_W = WORD_W - SMP_W;
   localparam int OCT_N  = WORD_W / OCTET_W;

   logic [FPW*SMP_W-1:0] smp_d;

   for (genvar f = 0; f < FPW; f++) begin : g_frame
      logic [WORD_W-1:0] word;
      for (genvar o = 0; o < OCT_N; o++) begin : g_oct
         assign word[WORD_W-1-o*OCTET_W -: OCTET_W] =
            lane_i[(FPW-f)*WORD_W-1-o*OCTET_W -: OCTET_W];
      end
      // drop the tail bits
      assign smp_d[f*SMP_W +: SMP_W] = word[WORD_W-1 -: SMP_W];
      if (TAIL_W > 0) begin : g_tail
         logic [TAIL_W-1:0] tail_unused;
         assign tail_unused = word[TAIL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     smp_o <= '0;
      else if (vld_i) smp_o <= smp_d;
   end
endmodule

// File: rtl/jtm_transport.sv
module jtm_transport
   import jtm_pkg::*;
#(
   parameter int SMP_W  = DEF_SMP_W,
   parameter int WORD_W = DEF_WORD_W,
   parameter int LANES  = DEF_LANES,
   parameter int FPW    = DEF_FPW
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tx_vld_i,
   input  logic [LANES*FPW*SMP_W-1:0]    tx_smp_i,
   output logic                          tx_vld_o,
   output logic [LANES*FPW*WORD_W-1:0]   tx_lane_o,
   input  logic                          rx_vld_i,
   input  logic [LANES*FPW*WORD_W-1:0]   rx_lane_i,
   output logic                          rx_vld_o,
   output logic [LANES*FPW*SMP_W-1:0]    rx_smp_o
);
   localparam int CONV_SMP_W  = FPW * SMP_W;
   localparam int CONV_LANE_W = FPW * WORD_W;

   if (WORD_W < SMP_W) begin : g_bad_word
      $error("word narrower than sample");
   end
   if (WORD_W % OCTET_W != 0) begin : g_bad_oct
      $error("word width not whole octets");
   end
   if (LANES < 1 || FPW < 1) begin : g_bad_cnt
      $error("lane and frame counts must be positive");
   end

   for (genvar c = 0; c < LANES; c++) begin : g_conv
      jtm_tx_lane #(.SMP_W(SMP_W), .WORD_W(WORD_W), .FPW(FPW)) u_tx (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld_i  (tx_vld_i),
         .smp_i  (tx_smp_i[c*CONV_SMP_W +: CONV_SMP_W]),
         .lane_o (tx_lane_o[c*CONV_LANE_W +: CONV_LANE_W])
      );
      jtm_rx_lane #(.SMP_W(SMP_W), .WORD_W(WORD_W), .FPW(FPW)) u_rx (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld_i  (rx_vld_i),
         .lane_i (rx_lane_i[c*CONV_LANE_W +: CONV_LANE_W]),
         .smp_o  (rx_smp_o[c*CONV_SMP_W +: CONV_SMP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_vld_o <= 1'b0;
         rx_vld_o <= 1'b0;
      end else begin
         tx_vld_o <= tx_vld_i;
         rx_vld_o <= rx_vld_i;
      end
   end
endmodule

// File: rtl/jtm_transport_chk.sv
module jtm_transport_chk
   import jtm_pkg::*;
#(
   parameter int SMP_W  = DEF_SMP_W,
   parameter int WORD_W = DEF_WORD_W,
   parameter int LANES  = DEF_LANES,
   parameter int FPW    = DEF_FPW
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tx_vld_i,
   input logic [LANES*FPW*SMP_W-1:0]    tx_smp_i,
   input logic                          tx_vld_o,
   input logic [LANES*FPW*WORD_W-1:0]   tx_lane_o,
   input logic                          rx_vld_i,
   input logic [LANES*FPW*WORD_W-1:0]   rx_lane_i,
   input logic                          rx_vld_o,
   input logic [LANES*FPW*SMP_W-1:0]    rx_smp_o
);
   localparam int TAIL_W = WORD_W - SMP_W;

   assert_tx_vld_dly_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld_i |=> tx_vld_o);
   assert_tx_vld_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_vld_i |=> !tx_vld_o);
   assert_rx_vld_dly_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld_i |=> rx_vld_o);
   assert_rx_vld_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld_i |=> !rx_vld_o);
   assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_vld_i |=> $stable(tx_lane_o));
   assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld_i |=> $stable(rx_smp_o));

   for (genvar c = 0; c < LANES; c++) begin : g_c
      for (genvar f = 0; f < FPW; f++) begin : g_f
         // R3/R5: converter c, frame f lands in lane c at its slot
         assert_tx_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tx_vld_i |=> tx_lane_o[c*FPW*WORD_W + (FPW-f)*WORD_W-1 -: SMP_W]
                         == $past(tx_smp_i[(c*FPW+f)*SMP_W +: SMP_W]));
         if (TAIL_W > 0) begin : g_t
            assert_tx_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
               tx_vld_o |-> tx_lane_o[c*FPW*WORD_W + (FPW-1-f)*WORD_W +: TAIL_W] == '0);
         end
         assert_rx_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rx_vld_i |=> rx_smp_o[(c*FPW+f)*SMP_W +: SMP_W]
                         == $past(rx_lane_i[c*FPW*WORD_W + (FPW-f)*WORD_W-1 -: SMP_W]));
      end
   end
endmodule

bind jtm_transport jtm_transport_chk #(
   .SMP_W(SMP_W), .WORD_W(WORD_W), .LANES(LANES), .FPW(FPW)
) u_chk (.*);

// File: tb/jtm_transport_tb.sv
module jtm_transport_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 56;
   localparam int LW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_vld_i = 1'b0;
   logic [SW-1:0] tx_smp_i = '0;
   logic          tx_vld_o;
   logic [LW-1:0] tx_lane_o;
   logic          rx_vld_i = 1'b0;
   logic [LW-1:0] rx_lane_i = '0;
   logic          rx_vld_o;
   logic [SW-1:0] rx_smp_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtm_transport u_dut (
      .clk(clk), .rst_n(rst_n),
      .tx_vld_i(tx_vld_i), .tx_smp_i(tx_smp_i),
      .tx_vld_o(tx_vld_o), .tx_lane_o(tx_lane_o),
      .rx_vld_i(rx_vld_i), .rx_lane_i(rx_lane_i),
      .rx_vld_o(rx_vld_o), .rx_smp_o(rx_smp_o)
   );

   // packing rule from the requirements
   function automatic logic [LW-1:0] pack(input logic [SW-1:0] s);
      logic [LW-1:0] r = '0;
      for (int c = 0; c < 2; c++)
         for (int f = 0; f < 2; f++)
            r[c*32 + (1-f)*16 +: 16] = {s[(c*2+f)*14 +: 14], 2'b00};
      return r;
   endfunction

   function automatic logic [SW-1:0] unpack(input logic [LW-1:0] d);
      logic [SW-1:0] r = '0;
      for (int c = 0; c < 2; c++)
         for (int f = 0; f < 2; f++)
            r[(c*2+f)*14 +: 14] = d[c*32 + (1-f)*16 + 2 +: 14];
      return r;
   endfunction

   task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_reset;
      #1;
      check("R1 tx_vld in reset", LW'(tx_vld_o), 0);
      check("R1 rx_vld in reset", LW'(rx_vld_o), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 tx_lane after reset", tx_lane_o, 0);
      check("R1 rx_smp after reset", LW'(rx_smp_o), 0);
      check("R1 tx_vld after reset", LW'(tx_vld_o), 0);
   endtask

   task automatic t_tx(input string req, input logic [SW-1:0] s);
      @(negedge clk); tx_vld_i = 1'b1; tx_smp_i = s;
      @(posedge clk); #1;
      check({req, " R2 tx_vld"}, LW'(tx_vld_o), 1);
      check({req, " tx_lane"}, tx_lane_o, pack(s));
      @(negedge clk); tx_vld_i = 1'b0;
      @(posedge clk); #1;
      check("R2 tx_vld drop", LW'(tx_vld_o), 0);
   endtask

   task automatic t_tx_layout;
      logic [SW-1:0] s = '0;
      // R3 R5: one marked sample per slot, fixed expected bit positions
      s[0 +: 14] = 14'h3FFF;                 // conv0 frame0 -> lane0 [31:18]
      @(negedge clk); tx_vld_i = 1'b1; tx_smp_i = s;
      @(posedge clk); #1;
      check("R5 frame0 upper half", tx_lane_o, 64'h0000_0000_FFFC_0000);
      check("R5 first octet bits31:24", LW'(tx_lane_o[31:24]), 64'hFF);
      @(negedge clk); s = '0; s[3*14 +: 14] = 14'h2001; tx_smp_i = s; // conv1 frame1
      @(posedge clk); #1;
      check("R3 conv1 on lane1 low half", tx_lane_o, 64'h0000_8004_0000_0000);
      check("R4 tail bits zero", LW'({tx_lane_o[49:48], tx_lane_o[33:32], tx_lane_o[17:16], tx_lane_o[1:0]}), 0);
      @(negedge clk); tx_vld_i = 1'b0;
   endtask

   task automatic t_rx(input string req, input logic [LW-1:0] d);
      @(negedge clk); rx_vld_i = 1'b1; rx_lane_i = d;
      @(posedge clk); #1;
      check({req, " R6 rx_vld"}, LW'(rx_vld_o), 1);
      check({req, " rx_smp"}, LW'(rx_smp_o), LW'(unpack(d)));
      @(negedge clk); rx_vld_i = 1'b0;
      @(posedge clk); #1;
      check("R6 rx_vld drop", LW'(rx_vld_o), 0);
   endtask

   task automatic t_rx_tail;
      logic [SW-1:0] base;
      @(negedge clk); rx_vld_i = 1'b1; rx_lane_i = 64'h1234_5678_9ABC_DEF0 & ~64'h0003_0003_0003_0003;
      @(posedge clk); #1;
      base = rx_smp_o;
      @(negedge clk); rx_lane_i = 64'h1234_5678_9ABC_DEF0 | 64'h0003_0003_0003_0003;
      @(posedge clk); #1;
      check("R7 tail ignored", LW'(rx_smp_o), LW'(base));
      check("R7 rx expected", LW'(rx_smp_o), LW'(unpack(64'h1234_5678_9ABC_DEF0)));
      @(negedge clk); rx_vld_i = 1'b0;
   endtask

   task automatic t_hold;
      logic [SW-1:0] s = 56'hA5_5A5A_A5A5_5A5A;
      logic [LW-1:0] d = 64'hCAFE_F00D_0BAD_BEEF;
      @(negedge clk); tx_vld_i = 1'b1; tx_smp_i = s; rx_vld_i = 1'b1; rx_lane_i = d;
      @(negedge clk); tx_vld_i = 1'b0; tx_smp_i = ~s; rx_vld_i = 1'b0; rx_lane_i = ~d;
      @(posedge clk); #1;
      check("R8 tx hold", tx_lane_o, pack(s));
      check("R8 rx hold", LW'(rx_smp_o), LW'(unpack(d)));
      @(posedge clk); #1;
      check("R8 tx hold 2", tx_lane_o, pack(s));
   endtask

   task automatic t_both;
      for (int i = 0; i < 6; i++) begin
         logic [SW-1:0] s = {24'(i * 32'h9E3779), 32'(i * 32'h1F2E3D4C)};
         logic [LW-1:0] d = {32'(i * 32'hDEADBEEF), 32'(~(i * 32'h01234567))};
         @(negedge clk); tx_vld_i = 1'b1; tx_smp_i = s; rx_vld_i = 1'b1; rx_lane_i = d;
         @(posedge clk); #1;
         check("R9 tx with rx busy", tx_lane_o, pack(s));
         check("R9 rx with tx busy", LW'(rx_smp_o), LW'(unpack(d)));
         check("R9 both valid", LW'({tx_vld_o, rx_vld_o}), 3);
      end
      @(negedge clk); tx_vld_i = 1'b0; rx_vld_i = 1'b0;
   endtask

   initial begin
      t_reset();
      t_tx("R3", 56'h12_3456_789A_BCDE);
      t_tx("R4", {4{14'h3FFF}});
      t_tx("R2", 56'h00_0000_0000_0001);
      t_tx_layout();
      t_rx("R6", 64'h8001_4002_2004_1008);
      t_rx("R3", 64'hFFFF_0000_0000_FFFF);
      t_rx_tail();
      t_hold();
      t_both();
      @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule